// File: doc/BRIEF.md
# Buffered Edge-Aligned PWM Channel

This block is a single pulse-width-modulation channel with a private up-counter. The counter advances only on cycles where a prescaled tick enable is high. A duty compare value sets how many ticks the output stays active after each period start. A period compare value sets how many ticks one period lasts. Software-side logic loads the duty value, the period value and a small control word through one narrow write port.

Duty and period writes land in holding buffers. The working compare values are reloaded from those buffers only when the counter wraps, so a period in progress is never disturbed. The control word has three fields. The first selects between generator mode and static-level mode. The second inverts the active level. The third is a level bit, which drives the pin in static mode and is also the pin value held from the moment generator mode is entered until the first tick. A period-start strobe marks every wrap, and an error strobe marks a rejected period write.

Top module: `pwm_edge_chan`

## Requirements
- R1: In generator mode the counter runs 1, 2, ... up to the working period P and then returns to 1, so a period lasts exactly P ticks. `bnd_o` is high for one clock in the cycle after each tick that starts a period, including the first tick after mode entry.
- R2: A duty or period write changes only the buffered value. The working values take the buffered values at the next period start and never inside a period. A write made in the same cycle as a period start applies from the period after that.
- R3: With working duty D and 0 < D < P, the output is active for counts 1..D and inactive for counts D+1..P, so the pulse lasts D ticks.
- R4: A duty of 0 holds the output inactive for the whole period, with no active cycle at the period start.
- R5: A duty greater than or equal to P holds the output active for the whole period.
- R6: A period write with a value V is accepted only when MIN_PERIOD < V <= MAX_PERIOD. With the defaults this means 2..250 is accepted and 0, 1 and 251 or more are refused. A refused write leaves the buffer unchanged and raises `err_o` for one clock. Duty writes never raise `err_o`.
- R7: Control bit 1 (active-low) inverts the pin: the active level is 0 when the bit is set and 1 when it is clear.
- R8: Control bit 0 selects generator mode. While it is 0, the pin follows control bit 2 and the counter stays at 0. A control write that sets bit 0 from 0 puts bit 2 on the pin in the next cycle and holds it there until the first tick, which starts a new period.
- R9: A control write takes priority over a tick in the same cycle. That tick is dropped: the counter and the pin do not advance. `wr_sel_i` encodes 0 = duty, 1 = period, 2 = control, and 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled count enable |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target: 0 duty, 1 period, 2 control |
| wr_data_i | input | CNT_W | Write value; for control, bit0 run, bit1 active-low, bit2 level |
| pwm_o | output | 1 | PWM output pin |
| bnd_o | output | 1 | Period-start strobe |
| err_o | output | 1 | Rejected period write strobe |

## Verification
The generator is exercised three ways: with a tick on every clock, with a tick every third clock, and with a pseudo-random tick pattern. These show, in turn, that the output follows the tick count and not the clock count, and that it holds its level between ticks. Duty is swept across zero, one, mid values, equal to the period and above the period. This separates the two saturated cases from the ordinary pulse edge. Writes are placed in the middle of a period and on the period-start cycle itself, which catches any reload that happens too early or one period late. Period writes just inside and just outside both limits, and control writes that coincide with ticks, are also covered.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  typedef enum logic [1:0] {
    SEL_DUTY   = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } wr_sel_e;

  // packed: edge_lvl = bit2, act_low = bit1, run = bit0
  typedef struct packed {
    logic edge_lvl;
    logic act_low;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int CNT_W      = 8,
  parameter int MIN_PERIOD = 1,
  parameter int MAX_PERIOD = 250
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             duty_we_i,
  input  logic             period_we_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] duty_buf_o,
  output logic [CNT_W-1:0] duty_act_o,
  output logic [CNT_W-1:0] period_act_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_PERIOD);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_PERIOD);

  logic [CNT_W-1:0] period_buf_q;
  logic             period_ok;

  assign period_ok = (data_i > MIN_V) && (data_i <= MAX_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_buf_o   <= '0;
      period_buf_q <= MAX_V;
      err_o        <= 1'b0;
    end else begin
      err_o <= period_we_i && !period_ok;
      if (duty_we_i) duty_buf_o <= data_i;
      if (period_we_i && period_ok) period_buf_q <= data_i;
    end
  end

  // working copies change only on a period start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_act_o   <= '0;
      period_act_o <= MAX_V;
    end else if (load_i) begin
      duty_act_o   <= duty_buf_o;
      period_act_o <= period_buf_q;
    end
  end

  a_r2_hold_working: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(duty_act_o) && $stable(period_act_o)));

  a_r6_reject_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_we_i && !((data_i > MIN_V) && (data_i <= MAX_V)))
      |=> (err_o && $stable(period_buf_q)));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             wrap_o,
  output logic             bnd_o
);
  logic [CNT_W-1:0] cnt_q;

  // count 0 means idle: the first tick after entry starts a period
  assign wrap_o    = adv_i && ((cnt_q == '0) || (cnt_q >= period_i));
  assign cnt_nxt_o = wrap_o ? CNT_W'(1) : cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bnd_o <= 1'b0;
    end else begin
      bnd_o <= wrap_o && !clr_i;
      if (clr_i)      cnt_q <= '0;
      else if (adv_i) cnt_q <= cnt_nxt_o;
    end
  end

  a_r1_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= period_i);

  a_r1_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_o |=> !bnd_o);

  a_r9_idle_on_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             force_i,
  input  logic             force_lvl_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             act_low_i,
  output logic             pin_o
);
  logic active;

  // active for counts 1..duty; duty 0 never, duty >= period always
  assign active = (cnt_nxt_i <= duty_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pin_o <= 1'b0;
    else if (force_i) pin_o <= force_lvl_i;
    else if (adv_i)   pin_o <= active ^ act_low_i;
  end

  a_r7_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_i && adv_i && (cnt_nxt_i == CNT_W'(1)) && (duty_i == '0))
      |=> (pin_o == $past(act_low_i)));
endmodule

// File: rtl/pwm_edge_chan.sv
module pwm_edge_chan #(
  parameter int CNT_W      = 8,
  parameter int MIN_PERIOD = 1,
  parameter int MAX_PERIOD = 250
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             pwm_o,
  output logic             bnd_o,
  output logic             err_o
);
  import pwm_chan_pkg::*;

  ctrl_t            ctrl_q, ctrl_new;
  logic             ctrl_we, duty_we, period_we;
  logic             entry, clr, adv, wrap;
  logic [CNT_W-1:0] cnt_nxt, duty_buf, duty_act, period_act, duty_use;

  assign ctrl_new  = ctrl_t'(wr_data_i[2:0]);
  assign ctrl_we   = wr_en_i && (wr_sel_e'(wr_sel_i) == SEL_CTRL);
  assign duty_we   = wr_en_i && (wr_sel_e'(wr_sel_i) == SEL_DUTY);
  assign period_we = wr_en_i && (wr_sel_e'(wr_sel_i) == SEL_PERIOD);
  assign entry     = ctrl_we && ctrl_new.run && !ctrl_q.run;
  // control write wins over a same-cycle tick
  assign clr       = ctrl_we ? (entry || !ctrl_new.run) : !ctrl_q.run;
  assign adv       = tick_i && ctrl_q.run && !ctrl_we;
  assign duty_use  = wrap ? duty_buf : duty_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_new;
  end

  pwm_shadow #(
    .CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD), .MAX_PERIOD(MAX_PERIOD)
  ) u_shadow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .duty_we_i   (duty_we),
    .period_we_i (period_we),
    .data_i      (wr_data_i),
    .load_i      (wrap),
    .duty_buf_o  (duty_buf),
    .duty_act_o  (duty_act),
    .period_act_o(period_act),
    .err_o       (err_o)
  );

  pwm_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .adv_i    (adv),
    .period_i (period_act),
    .cnt_nxt_o(cnt_nxt),
    .wrap_o   (wrap),
    .bnd_o    (bnd_o)
  );

  pwm_outstage #(.CNT_W(CNT_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .force_i    (clr),
    .force_lvl_i(ctrl_we ? ctrl_new.edge_lvl : ctrl_q.edge_lvl),
    .adv_i      (adv),
    .cnt_nxt_i  (cnt_nxt),
    .duty_i     (duty_use),
    .act_low_i  (ctrl_q.act_low),
    .pin_o      (pwm_o)
  );

  a_r8_static_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.run |-> (pwm_o == ctrl_q.edge_lvl));

  a_r8_entry_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry |=> (pwm_o == $past(wr_data_i[2])));

  a_r4_zero_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bnd_o && (duty_act == '0)) |-> (pwm_o == ctrl_q.act_low));

  a_r5_full_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bnd_o && (duty_act >= period_act)) |-> (pwm_o == !ctrl_q.act_low));

  a_r9_tick_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we && ctrl_q.run && ctrl_new.run) |=> ($stable(pwm_o) && !bnd_o));
endmodule

// File: tb/pwm_edge_chan_test.sv
module pwm_edge_chan_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int MINP = 1;
  localparam int MAXP = 250;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = 2'd3;
  logic [W-1:0] wr_data_i = '0;
  logic pwm_o, bnd_o, err_o;

  int n_run = 0;
  int n_fail = 0;
  string tag = "R0";

  // reference state
  int m_run, m_low, m_edge, m_abuf, m_bbuf, m_aact, m_bact, m_cnt, m_out, m_bnd, m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_edge_chan #(.CNT_W(W), .MIN_PERIOD(MINP), .MAX_PERIOD(MAXP)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .pwm_o(pwm_o), .bnd_o(bnd_o), .err_o(err_o)
  );

  task automatic check(string name, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_run = 0; m_low = 0; m_edge = 0; m_abuf = 0; m_bbuf = MAXP;
    m_aact = 0; m_bact = MAXP; m_cnt = 0; m_out = 0; m_bnd = 0; m_err = 0;
  endtask

  task automatic model_clock(int t, int we, int sel, int d);
    int cw, wrap, nxt, ause;
    cw   = (we != 0) && (sel == 2);
    wrap = !cw && m_run != 0 && t != 0 && (m_cnt == 0 || m_cnt >= m_bact);
    ause = wrap ? m_abuf : m_aact;
    m_err = (we != 0) && (sel == 1) && (d <= MINP || d > MAXP);
    m_bnd = wrap;
    if (cw) begin
      if ((d & 1) == 0 || m_run == 0) begin
        m_cnt = 0;
        m_out = (d >> 2) & 1;
      end
      m_run = d & 1; m_low = (d >> 1) & 1; m_edge = (d >> 2) & 1;
    end else if (m_run == 0) begin
      m_cnt = 0;
      m_out = m_edge;
    end else if (t != 0) begin
      nxt = wrap ? 1 : m_cnt + 1;
      m_out = ((nxt <= ause) ? 1 : 0) ^ m_low;
      m_cnt = nxt;
    end
    if (wrap) begin
      m_aact = m_abuf;
      m_bact = m_bbuf;
    end
    if (we != 0 && sel == 0) m_abuf = d;
    if (we != 0 && sel == 1 && d > MINP && d <= MAXP) m_bbuf = d;
  endtask

  // one clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic step(int t, int we, int sel, int d);
    tick_i = t[0]; wr_en_i = we[0]; wr_sel_i = sel[1:0]; wr_data_i = d[W-1:0];
    @(posedge clk);
    model_clock(t, we, sel, d);
    @(negedge clk);
    check("pwm_o", int'(pwm_o), m_out);
    check("bnd_o", int'(bnd_o), m_bnd);
    check("err_o", int'(err_o), m_err);
  endtask

  task automatic idle(int n, int every);
    for (int i = 0; i < n; i++) step((i % every) == every - 1, 0, 3, 0);
  endtask

  task automatic wr(int sel, int d, int t);
    step(t, 1, sel, d);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    tag = "R8";
    check("reset pwm_o", int'(pwm_o), 0);
    check("reset bnd_o", int'(bnd_o), 0);
    check("reset err_o", int'(err_o), 0);

    // R8 static mode follows level bit, ticks ignored
    wr(2, 3'b100, 1); idle(4, 1);
    wr(2, 3'b000, 0); idle(3, 1);

    // R8 entry: level bit held until first tick
    tag = "R1";
    wr(0, 3, 0); wr(1, 5, 0);
    wr(2, 3'b101, 0);
    idle(3, 1000);
    tag = "R3";
    idle(30, 1);

    // R2 mid-period and boundary-aligned writes
    tag = "R2";
    idle(2, 1);
    wr(0, 1, 1); wr(1, 8, 1);
    idle(20, 1);
    for (int i = 0; i < 16; i++) begin
      if (bnd_o) begin wr(0, 6, 1); break; end
      step(1, 0, 3, 0);
    end
    idle(20, 1);

    // R4 zero duty, R5 duty at and above period
    tag = "R4";
    wr(0, 0, 1); idle(20, 1);
    tag = "R5";
    wr(0, 8, 1); idle(20, 1);
    wr(0, 9, 1); idle(20, 1);

    // R6 period limits
    tag = "R6";
    wr(1, 1, 1); wr(1, 0, 1); wr(1, 251, 1); wr(1, 255, 1);
    wr(1, 250, 1); wr(1, 2, 1); wr(0, 200, 1);
    idle(20, 1);
    wr(1, 6, 0); wr(0, 2, 0);

    // R7 active-low with prescaled ticks
    tag = "R7";
    wr(2, 3'b011, 0); idle(60, 3);

    // R9 control write colliding with ticks
    tag = "R9";
    wr(2, 3'b001, 1); idle(4, 1);
    wr(2, 3'b011, 1); idle(4, 1);
    wr(2, 3'b111, 1); wr(2, 3'b001, 1); idle(10, 1);
    wr(3, 77, 1); idle(10, 1);

    // pseudo-random ticks and writes
    tag = "R3";
    lf = 16'hACE1;
    for (int i = 0; i < 1500; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[7:4] == 4'd0)       wr(0, int'(lf[11:8]), int'(lf[0]));
      else if (lf[7:4] == 4'd1)  wr(1, int'(lf[12:8]), int'(lf[0]));
      else if (lf[7:3] == 5'd4)  wr(2, int'({lf[9:8], 1'b1}), int'(lf[0]));
      else if (lf[7:2] == 6'd20) wr(2, int'(lf[10:8]), int'(lf[0]));
      else                       step(int'(lf[0] | lf[1]), 0, 3, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule